// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital front end of an 18-bit serial-input converter. The serial pins (clock, chip select, data), the load strobe, the hardware reset pin and the power-down pin all arrive from outside the chip. They pass through synchronizers into the system clock domain. Inside that domain, edge detectors recover the serial clock and chip-select transitions.

While chip select is low, data bits are shifted in MSB first. When chip select rises after a complete word, the word moves into an input register. An active-low load strobe makes the converter latch transparent, so that latch follows the input register. The converter code is taken directly from that latch.

Several static pins set the behaviour:
- One chooses the code loaded on reset: mid-scale or zero.
- One chooses straight binary or two's-complement input. Two's complement is mapped to offset binary by inverting the MSB as the word enters the input register.
- One chooses what the serial output returns. It either reads back the input register, or passes the shift register on so that devices can be chained.

A power-down input raises a flag that asks the analog side to ground its output. Register contents are kept while this flag is high.

Top module: `serial_dac_front`

## Requirements
- R1: A system reset (`rst`) or a low on `hw_rst_n` loads the reset code into both the input register and the latch. The reset code is 20000h when `rst_mid`=1 and 00000h when it is 0. The same reset drives `sdo_en` low.
- R2: Bits are captured only while `cs_n` is low, one per rising `sclk` edge, MSB first. `sclk` edges while `cs_n` is high leave the shift register unchanged.
- R3: `sdo_en` is low while `cs_n` is high, which stands for a high-impedance serial output.
- R4: When `cs_n` rises after at least 18 captured bits, the last 18 bits enter the input register. A frame with fewer bits leaves the input register unchanged.
- R5: While `load_n` is low, `dac_code` follows the input register. While it is high, `dac_code` holds its value.
- R6: With `fmt_binary`=1 a word is stored unchanged. With `fmt_binary`=0, bit 17 of the word is inverted before it is stored.
- R7: With `sdo_readback`=1, `sdo` presents the input register MSB first. The first bit appears when `cs_n` falls, and each following bit appears after a falling `sclk` edge.
- R8: With `sdo_readback`=0, `sdo` presents the bit at the top of the shift register, updated after each falling `sclk` edge. Every bit therefore reappears 18 serial clocks after it entered.
- R9: `pd_flag` follows `pd_req`. Entering and leaving power-down leaves `dac_code` unchanged.
- R10: A frame that is in progress when a hardware reset occurs is discarded. Later `sclk` edges and the `cs_n` rise of that frame do not load the input register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Active-low latch transparency strobe |
| hw_rst_n | input | 1 | Active-low hardware reset pin |
| pd_req | input | 1 | Active-high power-down request |
| rst_mid | input | 1 | Reset code select: 1 gives mid-scale, 0 gives zero |
| fmt_binary | input | 1 | 1 selects straight binary, 0 selects two's complement |
| sdo_readback | input | 1 | 1 selects input register readback, 0 selects chained shift out |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo`; low means high impedance |
| dac_code | output | 18 | Converter code from the latch |
| pd_flag | output | 1 | Request to ground the analog output |

## Verification
The bench builds the block with an 18-bit word and two synchronizer stages, the default values. With these values one serial half-period of six system clocks clears the full input latency. This lets the reference model be compared on every clock through complete frames, short frames, 36-bit chained frames and a hardware reset in the middle of a frame. Both reset codes, both data formats and both serial-output modes are covered. This brings into reach the MSB inversion, the transfer of the last 18 bits and the 18-clock pass-through delay.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef struct packed {
    logic sclk;
    logic sdi;
    logic cs_n;
    logic load_n;
    logic hwrst_n;
    logic pd;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

  localparam pins_t PINS_IDLE = '{
    sclk:    1'b0,
    sdi:     1'b0,
    cs_n:    1'b1,
    load_n:  1'b1,
    hwrst_n: 1'b1,
    pd:      1'b0
  };

  typedef enum logic {
    SDO_CHAIN    = 1'b0,
    SDO_READBACK = 1'b1
  } sdo_src_e;

endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
  parameter int              WIDTH  = 6,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= IDLE;
        else     chain[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         cs_low,
  input  logic         cs_fall,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sdi,
  input  logic         readback,
  input  logic [W-1:0] in_reg,
  output logic [W-1:0] word,
  output logic         frame_full,
  output logic [$clog2(W+1)-1:0] bit_cnt,
  output logic         sdo,
  output logic         sdo_en
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic [W-1:0]  shreg;
  logic [W-1:0]  rb;
  logic [CW-1:0] cnt;
  logic          live;

  always_ff @(posedge clk) begin
    if (clr) begin
      shreg  <= '0;
      rb     <= '0;
      cnt    <= '0;
      live   <= 1'b0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else begin
      sdo_en <= cs_low;
      if (cs_fall) begin
        live <= 1'b1;
        cnt  <= '0;
        rb   <= in_reg;
        sdo  <= readback ? in_reg[W-1] : shreg[W-1];
      end else if (cs_low && live) begin
        if (sclk_rise) begin
          shreg <= {shreg[W-2:0], sdi};
          rb    <= {rb[W-2:0], 1'b0};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (sclk_fall) begin
          sdo <= readback ? rb[W-1] : shreg[W-1];
        end
      end
    end
  end

  assign word       = shreg;
  assign frame_full = live && (cnt == CNT_MAX);
  assign bit_cnt    = cnt;

endmodule

// File: rtl/sdf_regs.sv
module sdf_regs #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         rst_mid,
  input  logic         fmt_binary,
  input  logic         take,
  input  logic         load_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] in_reg,
  output logic [W-1:0] latch
);

  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] rst_code;
  logic [W-1:0] coded;

  assign rst_code = rst_mid ? MID : ZERO;
  assign coded    = fmt_binary ? word : (word ^ MID);

  always_ff @(posedge clk) begin
    if (clr) begin
      in_reg <= rst_code;
      latch  <= rst_code;
    end else begin
      if (take)    in_reg <= coded;
      if (load_en) latch  <= in_reg;
    end
  end

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front #(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              load_n,
  input  logic              hw_rst_n,
  input  logic              pd_req,
  input  logic              rst_mid,
  input  logic              fmt_binary,
  input  logic              sdo_readback,
  output logic              sdo,
  output logic              sdo_en,
  output logic [DATA_W-1:0] dac_code,
  output logic              pd_flag
);
  import sdf_pkg::*;

  localparam int CW = $clog2(DATA_W + 1);

  pins_t raw_pins;
  pins_t s_pins;
  pins_t prev_pins;

  assign raw_pins = '{sclk: sclk, sdi: sdi, cs_n: cs_n, load_n: load_n,
                      hwrst_n: hw_rst_n, pd: pd_req};

  sdf_sync #(
    .WIDTH (PINS_W),
    .STAGES(SYNC_STAGES),
    .IDLE  (PINS_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_pins),
    .q  (s_pins)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_pins <= PINS_IDLE;
    else     prev_pins <= s_pins;
  end

  logic clr;
  logic s_cs_n;
  logic s_load_n;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign clr       = rst || !s_pins.hwrst_n;
  assign s_cs_n    = s_pins.cs_n;
  assign s_load_n  = s_pins.load_n;
  assign sclk_rise =  s_pins.sclk && !prev_pins.sclk;
  assign sclk_fall = !s_pins.sclk &&  prev_pins.sclk;
  assign cs_fall   = !s_pins.cs_n &&  prev_pins.cs_n;
  assign cs_rise   =  s_pins.cs_n && !prev_pins.cs_n;

  sdo_src_e          sdo_src;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] in_reg;
  logic [DATA_W-1:0] latch;
  logic              frame_full;
  logic [CW-1:0]     bit_cnt;

  assign sdo_src = sdo_readback ? SDO_READBACK : SDO_CHAIN;

  sdf_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .clr       (clr),
    .cs_low    (!s_cs_n),
    .cs_fall   (cs_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi       (s_pins.sdi),
    .readback  (sdo_src == SDO_READBACK),
    .in_reg    (in_reg),
    .word      (word),
    .frame_full(frame_full),
    .bit_cnt   (bit_cnt),
    .sdo       (sdo),
    .sdo_en    (sdo_en)
  );

  sdf_regs #(.W(DATA_W)) u_regs (
    .clk       (clk),
    .clr       (clr),
    .rst_mid   (rst_mid),
    .fmt_binary(fmt_binary),
    .take      (cs_rise && frame_full),
    .load_en   (!s_load_n),
    .word      (word),
    .in_reg    (in_reg),
    .latch     (latch)
  );

  assign dac_code = latch;

  always_ff @(posedge clk) begin
    if (rst) pd_flag <= 1'b0;
    else     pd_flag <= s_pins.pd;
  end

endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int W = 18
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic                   rst_mid,
  input logic                   s_cs_n,
  input logic                   s_load_n,
  input logic                   cs_fall,
  input logic                   cs_rise,
  input logic                   sclk_fall,
  input logic                   sdo,
  input logic                   sdo_en,
  input logic                   pd_flag,
  input logic [W-1:0]           dac_code,
  input logic [W-1:0]           in_reg,
  input logic [$clog2(W+1)-1:0] bit_cnt
);

  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(clr) && $stable(rst_mid)) |->
      (dac_code == (rst_mid ? MID : '0)) && (in_reg == dac_code) && !sdo_en);

  assert_bits_bounded_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    bit_cnt <= ($clog2(W+1))'(W));

  assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (s_cs_n && $past(s_cs_n)) |-> !sdo_en);

  assert_inreg_only_on_frame_end_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(cs_rise) && !$past(clr)) |-> $stable(in_reg));

  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(s_load_n) && !$past(clr)) |-> $stable(dac_code));

  assert_sdo_steady_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (sdo_en && $past(sdo_en) && !$past(sclk_fall) && !$past(cs_fall) && !$past(clr))
      |-> $stable(sdo));

  assert_pd_keeps_code_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    ($rose(pd_flag) && $past(s_load_n) && !$past(clr)) |-> $stable(dac_code));

endmodule

bind serial_dac_front sdf_checker #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .rst_mid  (rst_mid),
  .s_cs_n   (s_cs_n),
  .s_load_n (s_load_n),
  .cs_fall  (cs_fall),
  .cs_rise  (cs_rise),
  .sclk_fall(sclk_fall),
  .sdo      (sdo),
  .sdo_en   (sdo_en),
  .pd_flag  (pd_flag),
  .dac_code (dac_code),
  .in_reg   (in_reg),
  .bit_cnt  (bit_cnt)
);

// File: tb/serial_dac_front_test.sv
module serial_dac_front_test;

  localparam int W = 18;
  localparam int S = 2;
  localparam int H = 6;
  localparam logic [W-1:0] MIDV = 18'h20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1;
  logic hw_rst_n = 1'b1, pd_req = 1'b0;
  logic rst_mid = 1'b1, fmt_binary = 1'b1, sdo_readback = 1'b1;
  logic sdo, sdo_en, pd_flag;
  logic [W-1:0] dac_code;

  serial_dac_front #(.DATA_W(W), .SYNC_STAGES(S)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load_n(load_n), .hw_rst_n(hw_rst_n), .pd_req(pd_req),
    .rst_mid(rst_mid), .fmt_binary(fmt_binary), .sdo_readback(sdo_readback),
    .sdo(sdo), .sdo_en(sdo_en), .dac_code(dac_code), .pd_flag(pd_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model. Pin bits: {sclk, sdi, cs_n, load_n, hwrst_n, pd}
  localparam logic [5:0] IDLE = 6'b001110;
  logic [5:0] hist [0:S];
  logic [W-1:0] m_sh, m_rb, m_in, m_latch;
  int m_cnt;
  bit m_live, m_sdo, m_en, m_pd, started = 1'b0;

  always @(posedge clk) begin
    logic [5:0] cur, prv;
    logic [W-1:0] code, n_sh, n_rb, n_in, n_latch;
    int n_cnt;
    bit n_live, n_sdo, n_en;
    code = rst_mid ? MIDV : '0;
    if (rst) begin
      for (int i = 0; i <= S; i++) hist[i] = IDLE;
      m_sh = '0; m_rb = '0; m_cnt = 0; m_live = 0; m_sdo = 0; m_en = 0; m_pd = 0;
      m_in = code; m_latch = code; started = 1'b1;
    end else begin
      cur = hist[S-1]; prv = hist[S];
      n_sh = m_sh; n_rb = m_rb; n_in = m_in; n_latch = m_latch;
      n_cnt = m_cnt; n_live = m_live; n_sdo = m_sdo; n_en = m_en;
      if (!cur[1]) begin
        n_sh = '0; n_rb = '0; n_cnt = 0; n_live = 0; n_sdo = 0; n_en = 0;
        n_in = code; n_latch = code;
      end else begin
        n_en = !cur[3];
        if (!cur[3] && prv[3]) begin
          n_live = 1; n_cnt = 0; n_rb = m_in;
          n_sdo = sdo_readback ? m_in[W-1] : m_sh[W-1];
        end else if (!cur[3] && m_live) begin
          if (cur[5] && !prv[5]) begin
            n_sh = {m_sh[W-2:0], cur[4]};
            n_rb = {m_rb[W-2:0], 1'b0};
            if (m_cnt < W) n_cnt = m_cnt + 1;
          end
          if (!cur[5] && prv[5]) n_sdo = sdo_readback ? m_rb[W-1] : m_sh[W-1];
        end
        if (cur[3] && !prv[3] && m_live && m_cnt == W)
          n_in = fmt_binary ? m_sh : (m_sh ^ MIDV);
        if (!cur[2]) n_latch = m_in;
      end
      m_sh = n_sh; m_rb = n_rb; m_in = n_in; m_latch = n_latch;
      m_cnt = n_cnt; m_live = n_live; m_sdo = n_sdo; m_en = n_en;
      m_pd = cur[0];
      for (int i = S; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {sclk, sdi, cs_n, load_n, hw_rst_n, pd_req};
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R5 dac_code vs model", dac_code, m_latch);
      check(sdo_readback ? "R7 sdo vs model" : "R8 sdo vs model", sdo, m_sdo);
      check("R3 sdo_en vs model", sdo_en, m_en);
      check("R9 pd_flag vs model", pd_flag, m_pd);
    end
  end

  logic [63:0] cap;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    sdi = b;
    tick(H);
    cap = {cap[62:0], sdo};
    sclk = 1'b1;
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic frame(input int nbits, input logic [63:0] bits);
    cap = '0;
    cs_n = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) clock_bit(bits[nbits-1-i]);
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    tick(H);
    load_n = 1'b1;
    tick(H);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(H);
    check("R1 mid reset code", dac_code, MIDV);
    check("R3 sdo_en idle", sdo_en, 0);

    frame(18, 64'h2A5C3);
    check("R5 held without load", dac_code, MIDV);
    pulse_load();
    check("R4 word loaded", dac_code, 18'h2A5C3);

    frame(18, 64'h3FFFF);
    check("R7 readback stream", cap[17:0], 18'h2A5C3);
    pulse_load();
    check("R5 follows after load", dac_code, 18'h3FFFF);

    frame(10, 64'h155);
    frame(18, 64'h0);
    check("R4 short frame discarded", cap[17:0], 18'h3FFFF);

    fmt_binary = 1'b0;
    frame(18, 64'h00001);
    pulse_load();
    check("R6 twos complement MSB inverted", dac_code, 18'h20001);
    fmt_binary = 1'b1;

    sdo_readback = 1'b0;
    frame(18, 64'h12345);
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
    end
    sdi = 1'b0;
    frame(36, {28'h0, 18'h0F0F0, 18'h31337});
    check("R2 no bits taken with cs high", cap[35:18], 18'h12345);
    check("R8 chained pass-through", cap[17:0], 18'h0F0F0);
    pulse_load();
    check("R4 last 18 bits kept", dac_code, 18'h31337);

    pd_req = 1'b1;
    tick(H);
    check("R9 power-down flag set", pd_flag, 1);
    check("R9 code kept in power-down", dac_code, 18'h31337);
    pd_req = 1'b0;
    tick(H);
    check("R9 power-down flag clear", pd_flag, 0);
    check("R9 code restored", dac_code, 18'h31337);

    rst_mid = 1'b0;
    sdo_readback = 1'b1;
    cs_n = 1'b0;
    tick(H);
    for (int i = 0; i < 9; i++) clock_bit(1'b1);
    hw_rst_n = 1'b0;
    tick(H);
    check("R1 zero reset code", dac_code, 0);
    check("R1 sdo_en low in reset", sdo_en, 0);
    hw_rst_n = 1'b1;
    tick(H);
    for (int i = 0; i < 9; i++) clock_bit(1'b1);
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
    pulse_load();
    check("R10 interrupted frame discarded", dac_code, 0);

    rst_mid = 1'b1;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(H);
    check("R1 system reset mid code", dac_code, MIDV);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule